// File: doc/BRIEF.md
# Compressed Instruction Stream Decoder

This block sits on the path from the instruction cache to the processor fetch port. It receives compressed code one byte per handshake. It rebuilds full 32-bit instructions and hands them out one at a time over a ready/valid pair. The stream is a run of bit-packed items. Bits are taken from each byte most significant bit first. Each item opens with a variable-length class prefix. One class carries a raw instruction. One indexes a preloaded expansion table whose entries yield one or two instructions. One rebuilds a conditional branch from a short header and a variable number of offset bytes. One is a small immediate form built from an opcode template.

Compressed code is split into blocks, and a fetch may begin at any block. A one-cycle block-start strobe discards every bit held in the internal shift buffer, including a partly received item and any padding bits up to the byte boundary. It also drops a pending output and sends the parser back to prefix parsing. The expansion table is loaded through a plain write port before the code that uses it runs.

Top module: `cdec_top`

## Requirements
- R1: The first stream bits select the class: `0` immediate (12 bits in all), `11` branch (9 bits plus 8 per offset byte), `100` table entry (3 plus 8 index bits), `101` raw (35 bits). Instructions leave in stream order and no item is emitted before all of its bits have arrived.
- R2: A raw item gives out the 32 bits that follow its prefix unchanged, first bit as bit 31.
- R3: A table item takes the 8 bits after its prefix as the index. When bit 63 of the entry is 0, it emits entry bits 31:0 as a single instruction.
- R4: When bit 63 of the entry is 1, a table item emits two instructions in turn: first entry bits 31:0, then {1'b0, entry bits 62:32}.
- R5: A branch item carries, after its prefix, an annul bit, a 4-bit condition and a 2-bit count n. The output is {2'b00, annul, condition, 3'b010, disp[21:0]}.
- R6: For n of 1, 2 or 3, the n offset bytes that follow (most significant first) are sign-extended and the low 22 bits become disp. For n of 0, no byte follows and disp is zero.
- R7: An immediate item carries a 3-bit template index k and then one byte v. The output is {2'b10, k, 13'b0, 1'b1, 5'b0, v}.
- R8: While outValid is high and outReady is low, outValid stays high and outInstr stays unchanged, unless blockStart is asserted.
- R9: The buffer holds at most 96 bits. inReady is low whenever more than 88 bits are held. After reset, with the output stalled and a stream of 35-bit raw items offered, exactly 16 bytes are taken.
- R10: While blockStart is high, inReady is low. In the cycle after it, outValid is low and no bits are held. The next byte then starts a fresh item.
- R11: After reset, outValid is low and inReady is high.
- R12: A table write takes effect for every table item decoded after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| blockStart | input | 1 | Block boundary strobe: flush and restart parsing |
| inByte | input | 8 | Compressed stream byte |
| inValid | input | 1 | inByte is valid |
| inReady | output | 1 | Byte will be taken at this edge |
| outInstr | output | 32 | Rebuilt instruction |
| outValid | output | 1 | outInstr is valid |
| outReady | input | 1 | Consumer takes outInstr |
| dictWrEn | input | 1 | Expansion table write enable |
| dictWrIdx | input | 8 | Expansion table write index |
| dictWrData | input | 64 | Expansion table entry, bit 63 marks a pair |

## Verification
A wrong bit count or a wrong shift amount throws the bit alignment off for every later item. The error shows at outInstr on the next item, usually as the wrong class. It keeps showing until the next block start, and the random blocks expose it within a few instructions. A stale second-word register or a missed pair flag gives one extra or one missing instruction. That shifts every later comparison. A flush that leaves bits behind corrupts the first instruction after the block start. An off-by-one fill limit changes the count of bytes taken while the output is stalled.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

  localparam int INSTR_W = 32;
  localparam int ENTRY_W = 2 * INSTR_W;
  localparam int WIN_W   = INSTR_W + 3;
  localparam int IMM_LEN = 12;
  localparam int BR_HDR  = 9;
  localparam int RAW_LEN = WIN_W;

  typedef struct packed {
    logic flush;
    logic consume;
    logic loadFirst;
    logic loadSecond;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_PARSE     = 2'd0,
    ST_EMIT_PAIR = 2'd1,
    ST_EMIT_LAST = 2'd2
  } decState_t;

  // offBytes holds the first offset byte in its top eight bits
  function automatic logic [INSTR_W-1:0] rebuildBranch(
    input logic        annul,
    input logic [3:0]  cond,
    input logic [1:0]  nBytes,
    input logic [23:0] offBytes
  );
    logic [23:0] ext;
    case (nBytes)
      2'd1:    ext = {{16{offBytes[23]}}, offBytes[23:16]};
      2'd2:    ext = {{8{offBytes[23]}}, offBytes[23:8]};
      2'd3:    ext = offBytes;
      default: ext = '0;
    endcase
    return {2'b00, annul, cond, 3'b010, ext[21:0]};
  endfunction

endpackage

// File: rtl/cdec_dict.sv
module cdec_dict
  import cdec_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [ENTRY_W-1:0] rdData
);

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrIdx] <= wrData;
  end

  assign rdData = mem[rdIdx];

endmodule

// File: rtl/cdec_datapath.sv
module cdec_datapath
  import cdec_pkg::*;
#(
  parameter int BUF_W = 96,
  parameter int IDX_W = 8,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [7:0]         inByte,
  input  logic               inValid,
  output logic               inReady,
  output logic [IDX_W-1:0]   dictRdIdx,
  input  logic [ENTRY_W-1:0] dictRdData,
  output logic               itemDone,
  output logic               itemPair,
  output logic [INSTR_W-1:0] outInstr,
  output logic [CNT_W-1:0]   fillLevel
);

  localparam int DICT_LEN = 3 + IDX_W;

  logic [BUF_W-1:0]   bitBuf, nextBuf;
  logic [CNT_W-1:0]   bitCnt, nextCnt, itemLen, consumeLen, remain;
  logic [WIN_W-1:0]   win;
  logic [INSTR_W-1:0] firstWord, outWord, hiWord;
  logic               byteTake;

  assign win       = bitBuf[BUF_W-1 -: WIN_W];
  assign dictRdIdx = win[WIN_W-4 -: IDX_W];
  assign inReady   = !ctl.flush && (bitCnt <= CNT_W'(BUF_W - 8));
  assign byteTake  = inValid && inReady;
  assign fillLevel = bitCnt;
  assign outInstr  = outWord;

  // prefix parse and item completeness
  always_comb begin
    itemLen   = '0;
    itemDone  = 1'b0;
    itemPair  = 1'b0;
    firstWord = '0;
    if (bitCnt != '0) begin
      if (!win[WIN_W-1]) begin
        itemLen   = CNT_W'(IMM_LEN);
        itemDone  = bitCnt >= itemLen;
        firstWord = {2'b10, win[WIN_W-2 -: 3], 13'd0, 1'b1, 5'd0, win[WIN_W-5 -: 8]};
      end else if (bitCnt >= CNT_W'(2)) begin
        if (win[WIN_W-2]) begin
          if (bitCnt >= CNT_W'(BR_HDR)) begin
            itemLen   = CNT_W'(BR_HDR) + CNT_W'({win[WIN_W-8 -: 2], 3'b000});
            itemDone  = bitCnt >= itemLen;
            firstWord = rebuildBranch(win[WIN_W-3], win[WIN_W-4 -: 4],
                                      win[WIN_W-8 -: 2], win[WIN_W-10 -: 24]);
          end
        end else if (bitCnt >= CNT_W'(3)) begin
          if (!win[WIN_W-3]) begin
            itemLen   = CNT_W'(DICT_LEN);
            itemDone  = bitCnt >= itemLen;
            itemPair  = dictRdData[ENTRY_W-1];
            firstWord = dictRdData[INSTR_W-1:0];
          end else begin
            itemLen   = CNT_W'(RAW_LEN);
            itemDone  = bitCnt >= itemLen;
            firstWord = win[INSTR_W-1:0];
          end
        end
      end
    end
  end

  // shift out the finished item and append the incoming byte behind what remains
  always_comb begin
    consumeLen = ctl.consume ? itemLen : '0;
    remain     = bitCnt - consumeLen;
    nextBuf    = bitBuf << consumeLen;
    nextCnt    = remain;
    if (byteTake) begin
      nextBuf = nextBuf | ({inByte, {(BUF_W-8){1'b0}}} >> remain);
      nextCnt = remain + CNT_W'(8);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitBuf  <= '0;
      bitCnt  <= '0;
      outWord <= '0;
      hiWord  <= '0;
    end else begin
      if (ctl.flush) begin
        bitBuf <= '0;
        bitCnt <= '0;
      end else begin
        bitBuf <= nextBuf;
        bitCnt <= nextCnt;
      end
      if (ctl.loadFirst) begin
        outWord <= firstWord;
        hiWord  <= {1'b0, dictRdData[ENTRY_W-2:INSTR_W]};
      end else if (ctl.loadSecond) begin
        outWord <= hiWord;
      end
    end
  end

endmodule

// File: rtl/cdec_control.sv
module cdec_control
  import cdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       blockStart,
  input  logic       itemDone,
  input  logic       itemPair,
  input  logic       outReady,
  output ctlStrobe_t ctl,
  output logic       outValid
);

  decState_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    if (blockStart) begin
      ctl.flush = 1'b1;
      stateNext = ST_PARSE;
    end else begin
      case (state)
        ST_PARSE: begin
          if (itemDone) begin
            ctl.consume   = 1'b1;
            ctl.loadFirst = 1'b1;
            stateNext     = itemPair ? ST_EMIT_PAIR : ST_EMIT_LAST;
          end
        end
        ST_EMIT_PAIR: begin
          if (outReady) begin
            ctl.loadSecond = 1'b1;
            stateNext      = ST_EMIT_LAST;
          end
        end
        ST_EMIT_LAST: begin
          if (outReady) stateNext = ST_PARSE;
        end
        default: stateNext = ST_PARSE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PARSE;
    else       state <= stateNext;
  end

  assign outValid = (state != ST_PARSE);

endmodule

// File: rtl/cdec_top.sv
module cdec_top
  import cdec_pkg::*;
#(
  parameter int BUF_W = 96,
  parameter int IDX_W = 8,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               blockStart,
  input  logic [7:0]         inByte,
  input  logic               inValid,
  output logic               inReady,
  output logic [INSTR_W-1:0] outInstr,
  output logic               outValid,
  input  logic               outReady,
  input  logic               dictWrEn,
  input  logic [IDX_W-1:0]   dictWrIdx,
  input  logic [ENTRY_W-1:0] dictWrData
);

  ctlStrobe_t         ctl;
  logic               itemDone, itemPair;
  logic [IDX_W-1:0]   dictRdIdx;
  logic [ENTRY_W-1:0] dictRdData;
  logic [CNT_W-1:0]   fillLevel;

  cdec_dict #(.IDX_W(IDX_W)) dict_i (
    .clk    (clk),
    .wrEn   (dictWrEn),
    .wrIdx  (dictWrIdx),
    .wrData (dictWrData),
    .rdIdx  (dictRdIdx),
    .rdData (dictRdData)
  );

  cdec_datapath #(.BUF_W(BUF_W), .IDX_W(IDX_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .inByte     (inByte),
    .inValid    (inValid),
    .inReady    (inReady),
    .dictRdIdx  (dictRdIdx),
    .dictRdData (dictRdData),
    .itemDone   (itemDone),
    .itemPair   (itemPair),
    .outInstr   (outInstr),
    .fillLevel  (fillLevel)
  );

  cdec_control ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .blockStart (blockStart),
    .itemDone   (itemDone),
    .itemPair   (itemPair),
    .outReady   (outReady),
    .ctl        (ctl),
    .outValid   (outValid)
  );

endmodule

// File: rtl/cdec_checker.sv
module cdec_checker #(
  parameter int BUF_W = 96,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             blockStart,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [31:0]      outInstr,
  input logic [CNT_W-1:0] fillLevel
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(BUF_W));                                         // R9
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel > CNT_W'(BUF_W - 8)) |-> !inReady);                       // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !blockStart) |=> (outValid && $stable(outInstr))); // R8
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    blockStart |=> (!outValid && fillLevel == '0));                      // R10
  AST_FLUSH_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    blockStart |-> !inReady);                                            // R10

endmodule

bind cdec_top cdec_checker #(.BUF_W(BUF_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .blockStart (blockStart),
  .inReady    (inReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .outInstr   (outInstr),
  .fillLevel  (fillLevel)
);

// File: tb/cdec_top_tb_top.sv
module cdec_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blockStart = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] outInstr;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        dictWrEn = 1'b0;
  logic [7:0]  dictWrIdx = '0;
  logic [63:0] dictWrData = '0;

  always #5 clk = ~clk;

  cdec_top dut_i (
    .clk(clk), .rstN(rstN), .blockStart(blockStart),
    .inByte(inByte), .inValid(inValid), .inReady(inReady),
    .outInstr(outInstr), .outValid(outValid), .outReady(outReady),
    .dictWrEn(dictWrEn), .dictWrIdx(dictWrIdx), .dictWrData(dictWrData)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [63:0] dictM [256];
  logic [7:0]  byteQ [$];
  logic [31:0] expQ [$];
  string       reqQ [$];
  logic [7:0]  pend = '0;
  int          pendN = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] expImm(input logic [2:0] k, input logic [7:0] v);
    return {2'b10, k, 13'd0, 1'b1, 5'd0, v};
  endfunction

  function automatic logic [31:0] expBranch(input logic a, input logic [3:0] c, input int n, input logic [23:0] off);
    logic [23:0] s;
    if (n == 1)      s = {{16{off[7]}}, off[7:0]};
    else if (n == 2) s = {{8{off[15]}}, off[15:0]};
    else if (n == 3) s = off;
    else             s = '0;
    return {2'b00, a, c, 3'b010, s[21:0]};
  endfunction

  task automatic pushBit(input logic b);
    pend = {pend[6:0], b};
    pendN++;
    if (pendN == 8) begin
      byteQ.push_back(pend);
      pendN = 0;
    end
  endtask

  task automatic putBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pushBit(v[i]);
  endtask

  task automatic padToByte();
    while (pendN != 0) pushBit(1'b0);
  endtask

  task automatic addRaw(input logic [31:0] w);
    putBits(32'b101, 3); putBits(w, 32);
    expQ.push_back(w); reqQ.push_back("R2 raw");
  endtask

  task automatic addImm(input logic [2:0] k, input logic [7:0] v);
    putBits(32'b0, 1); putBits({29'd0, k}, 3); putBits({24'd0, v}, 8);
    expQ.push_back(expImm(k, v)); reqQ.push_back("R7 immediate");
  endtask

  task automatic addBranch(input logic a, input logic [3:0] c, input int n, input logic [23:0] off);
    putBits(32'b11, 2); putBits({31'd0, a}, 1); putBits({28'd0, c}, 4); putBits(n, 2);
    for (int i = n - 1; i >= 0; i--) putBits({24'd0, off[i*8 +: 8]}, 8);
    expQ.push_back(expBranch(a, c, n, off));
    reqQ.push_back(n == 0 ? "R5 branch" : "R6 branch offset");
  endtask

  task automatic addDict(input logic [7:0] idx);
    putBits(32'b100, 3); putBits({24'd0, idx}, 8);
    expQ.push_back(dictM[idx][31:0]);
    if (dictM[idx][63]) begin
      reqQ.push_back("R4 pair first");
      expQ.push_back({1'b0, dictM[idx][62:32]}); reqQ.push_back("R4 pair second");
    end else begin
      reqQ.push_back("R3 dictionary");
    end
  endtask

  task automatic writeDict(input logic [7:0] idx, input logic [63:0] d);
    @(negedge clk); dictWrEn = 1'b1; dictWrIdx = idx; dictWrData = d;
    @(negedge clk); dictWrEn = 1'b0;
    dictM[idx] = d;
  endtask

  task automatic addRandomItem();
    int sel = $urandom % 4;
    case (sel)
      0: addRaw($urandom);
      1: addImm(3'($urandom), 8'($urandom));
      2: addBranch(1'($urandom), 4'($urandom), $urandom % 4, 24'($urandom));
      default: addDict(8'($urandom));
    endcase
  endtask

  task automatic runBlock(input int startIdx, input int readyPct, input int gapPct);
    int got = 0;
    fork
      begin
        for (int i = startIdx; i < byteQ.size(); i++) begin
          while (($urandom % 100) < gapPct) begin @(negedge clk); inValid = 1'b0; end
          @(negedge clk); inValid = 1'b1; inByte = byteQ[i]; #1;
          while (!inReady) begin @(negedge clk); #1; end
        end
        @(negedge clk); inValid = 1'b0;
      end
      begin
        bit held = 1'b0;
        logic [31:0] heldV = '0;
        while (got < expQ.size()) begin
          @(negedge clk); outReady = (($urandom % 100) < readyPct); #1;
          if (held) check(outValid && outInstr == heldV, "R8 hold while stalled", outInstr, heldV);
          held = 1'b0;
          if (outValid) begin
            if (outReady) begin
              check(outInstr == expQ[got], reqQ[got], outInstr, expQ[got]);
              got++;
            end else begin
              held = 1'b1; heldV = outInstr;
            end
          end
        end
        @(negedge clk); outReady = 1'b0;
      end
    join
  endtask

  task automatic endBlock();
    @(negedge clk); blockStart = 1'b1; #1;
    check(!inReady, "R10 no byte taken at block start", {31'd0, inReady}, 32'd0);
    @(negedge clk); blockStart = 1'b0; #1;
    check(!outValid, "R10 output dropped after block start", {31'd0, outValid}, 32'd0);
    byteQ.delete(); expQ.delete(); reqQ.delete(); pendN = 0;
  endtask

  initial begin
    int acc;
    int seedDummy;
    seedDummy = $urandom(32'h1a2b3c);
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;
    check(!outValid, "R11 reset outValid", {31'd0, outValid}, 32'd0);
    check(inReady, "R11 reset inReady", {31'd0, inReady}, 32'd1);

    for (int i = 0; i < 256; i++) writeDict(8'(i), {32'($urandom), 32'($urandom)});
    writeDict(8'd3, 64'h8765_4321_dead_beef);
    writeDict(8'd4, 64'h7fff_0000_1234_5678);

    // directed block covering every class and offset length
    addRaw(32'hffff_ffff); addRaw(32'h0000_0000);
    for (int k = 0; k < 8; k++) addImm(3'(k), 8'(8'h81 + k));
    addBranch(1'b1, 4'hA, 0, 24'h0);
    addBranch(1'b0, 4'h3, 1, 24'h00_007f);
    addBranch(1'b1, 4'h5, 1, 24'h00_0080);
    addBranch(1'b0, 4'h9, 2, 24'h00_8001);
    addBranch(1'b1, 4'hF, 3, 24'h7f_ffff);
    addBranch(1'b0, 4'h1, 3, 24'hc0_0001);
    addDict(8'd3); addDict(8'd4); addDict(8'd3);
    padToByte();
    runBlock(0, 100, 0);
    endBlock();

    // random blocks
    for (int b = 0; b < 8; b++) begin
      for (int j = 0; j < 30; j++) addRandomItem();
      padToByte();
      runBlock(0, 60, 30);
      endBlock();
    end

    // R9: fill limit with the output stalled
    for (int j = 0; j < 5; j++) addRaw($urandom);
    padToByte();
    acc = 0;
    outReady = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      inValid = (acc < byteQ.size());
      if (inValid) inByte = byteQ[acc];
      #1;
      if (inValid && inReady) acc++;
    end
    @(negedge clk); inValid = 1'b0; #1;
    check(acc == 16, "R9 bytes taken while stalled", 32'(acc), 32'd16);
    check(!inReady, "R9 inReady low when full", {31'd0, inReady}, 32'd0);
    runBlock(acc, 70, 20);
    endBlock();

    // R10: partial item abandoned at a block start
    addRaw(32'h1234_5678);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); inValid = 1'b1; inByte = byteQ[i]; #1;
      while (!inReady) begin @(negedge clk); #1; end
    end
    @(negedge clk); inValid = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    check(!outValid, "R1 no emission of a partial item", {31'd0, outValid}, 32'd0);
    endBlock();
    addImm(3'd5, 8'h3c); addBranch(1'b1, 4'h7, 2, 24'h00_fffe);
    padToByte();
    runBlock(0, 100, 0);
    endBlock();

    // R10: pending output dropped by a block start
    addImm(3'd2, 8'h99);
    padToByte();
    for (int i = 0; i < byteQ.size(); i++) begin
      @(negedge clk); inValid = 1'b1; inByte = byteQ[i]; #1;
      while (!inReady) begin @(negedge clk); #1; end
    end
    @(negedge clk); inValid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(outValid && outInstr == expImm(3'd2, 8'h99), "R7 immediate held", outInstr, expImm(3'd2, 8'h99));
    endBlock();

    // R12: rewrite an entry and decode it
    writeDict(8'd4, 64'h8000_0001_cafe_f00d);
    addDict(8'd4); addRaw(32'h0bad_cafe);
    padToByte();
    runBlock(0, 80, 10);
    check(1'b1, "R12 rewritten entry decoded", 32'd0, 32'd0);
    endBlock();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule